// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block tracks load-linked / store-conditional reservations for a small group of processors that share memory. Each processor port has a one-bit local tag, and a shared table holds one address reservation per processor, kept at word granularity. A load-exclusive sets the local tag and records the word it addressed. A later store-exclusive from the same port is allowed to commit only while both levels still hold and the addresses match.

The two levels are cleared by different events. A clear-exclusive request drops only the local tag. A store-exclusive or an exception entry drops the local tag and that processor's table entry. A successful write by any other processor to a reserved word cancels that reservation.

For every store-exclusive the block answers in the same cycle, with no register in the path. It gives a status bit and a write enable toward memory. State updates on the next rising clock edge. When several ports request in one cycle, a fixed priority decides the outcome, and the lowest port index wins.

Top module: `excl_resv_monitor`

## Requirements
- R1: A load-exclusive sets the issuing port's local tag and records its word (address bits AW-1:2) in that port's table entry. In the same cycle, an exception entry on that port overrides the load.
- R2: `stx_fail_o[p]` is 0 when the store-exclusive commits and 1 when it does not, and it is 0 on a cycle with no store-exclusive. For a store-exclusive alone, `mem_we_o[p]` equals the inverse of the status.
- R3: A store-exclusive clears the issuing port's local tag and table entry, whether or not it succeeds.
- R4: Exception entry clears that port's local tag and table entry. A store-exclusive issued in the same cycle as an exception entry fails.
- R5: A clear-exclusive clears only the local tag of its port. Table entries are not changed.
- R6: A store-exclusive succeeds only if the local tag is set, the port's table entry is valid, and the entry's word equals the store's word. Byte offsets within a word are ignored.
- R7: A successful write by another port to a reserved word cancels that reservation. This covers an ordinary store and a committed store-exclusive. A port's own ordinary store does not cancel its own reservation, and a failed store-exclusive cancels nothing.
- R8: When several ports issue passing store-exclusives to the same word in one cycle, only the lowest-index port succeeds. Store-exclusives to different words in the same cycle can all succeed.
- R9: A store-exclusive fails if another port issues an ordinary store to the same word in the same cycle.
- R10: A load-exclusive issued in the same cycle as another port's successful write to the same word does not leave a valid reservation.
- R11: A new load-exclusive replaces the port's earlier reservation, so each port holds at most one.
- R12: After reset, all local tags and table entries are invalid.
- R13: An ordinary store always raises `mem_we_o` for its port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ldx_vld_i | input | NP | Load-exclusive request, one bit per port |
| ldx_addr_i | input | NP*AW | Load-exclusive byte addresses, port p at bits p*AW +: AW |
| stx_vld_i | input | NP | Store-exclusive request per port |
| stx_addr_i | input | NP*AW | Store-exclusive byte addresses |
| clrx_i | input | NP | Clear-exclusive request per port |
| exc_i | input | NP | Exception entry per port |
| st_vld_i | input | NP | Ordinary store per port |
| st_addr_i | input | NP*AW | Ordinary store byte addresses |
| stx_fail_o | output | NP | Store-exclusive status, 1 means no write |
| mem_we_o | output | NP | Write enable toward memory per port |

## Verification
The embedded assertions check on every cycle that the tag and table entry react correctly to each clearing event. They also check that no two ports commit to the same word at once, that a commit always rests on a live reservation, and that a failed store-exclusive never writes. Several things can only be shown by the directed scenarios, because they depend on sequences: a canceling write arriving between load and store, replacement of an older reservation, word-granular matching of byte addresses, and same-cycle priority between ports. The scenarios also show that clear-exclusive leaves the other port's reservation alone.

// File: rtl/excl_resv_pkg.sv
package excl_resv_pkg;

  typedef enum logic [1:0] {
    TA_HOLD  = 2'd0,
    TA_SET   = 2'd1,
    TA_CLEAR = 2'd2
  } tag_act_e;

  // Priority of per-port events on a tag: exception, then load, then the clearing requests.
  function automatic tag_act_e local_action(input logic exc, input logic ldx,
                                            input logic stx, input logic clrx);
    if (exc)              return TA_CLEAR;
    else if (ldx)         return TA_SET;
    else if (stx || clrx) return TA_CLEAR;
    else                  return TA_HOLD;
  endfunction

  function automatic logic apply_action(input tag_act_e act, input logic cur);
    case (act)
      TA_SET:   return 1'b1;
      TA_CLEAR: return 1'b0;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/excl_local_tag.sv
module excl_local_tag
  import excl_resv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ldx_i,
  input  logic stx_i,
  input  logic clrx_i,
  input  logic exc_i,
  output logic tag_o
);

  tag_act_e act;
  logic     tag_q;

  always_comb act = local_action(exc_i, ldx_i, stx_i, clrx_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= 1'b0;
    else        tag_q <= apply_action(act, tag_q);
  end

  assign tag_o = tag_q;

  AST_LD_SETS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ldx_i && !exc_i) |=> tag_o); // R1
  AST_STX_DROPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stx_i && !ldx_i) |=> !tag_o); // R3
  AST_EXC_DROPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> !tag_o); // R4
  AST_CLR_DROPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clrx_i && !ldx_i) |=> !tag_o); // R5

endmodule

// File: rtl/excl_global_entry.sv
module excl_global_entry #(
  parameter int GW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ldx_i,
  input  logic [GW-1:0] ldx_gran_i,
  input  logic          stx_i,
  input  logic          exc_i,
  input  logic          kill_held_i,
  input  logic          kill_new_i,
  output logic          valid_o,
  output logic [GW-1:0] gran_o
);

  logic          valid_q, valid_d;
  logic [GW-1:0] gran_q, gran_d;

  always_comb begin
    valid_d = valid_q;
    gran_d  = gran_q;
    if (exc_i) begin
      valid_d = 1'b0;
    end else if (ldx_i) begin
      valid_d = !kill_new_i;
      gran_d  = ldx_gran_i;
    end else if (stx_i || kill_held_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      gran_q  <= '0;
    end else begin
      valid_q <= valid_d;
      gran_q  <= gran_d;
    end
  end

  assign valid_o = valid_q;
  assign gran_o  = gran_q;

  AST_EXC_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> !valid_o); // R4
  AST_STX_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (stx_i && !ldx_i) |=> !valid_o); // R3
  AST_SNOOP_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_held_i && !ldx_i) |=> !valid_o); // R7
  AST_SNOOP_BEATS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ldx_i && kill_new_i) |=> !valid_o); // R10
  AST_LOAD_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ldx_i && !exc_i && !kill_new_i) |=> (valid_o && gran_o == $past(ldx_gran_i))); // R11

endmodule

// File: rtl/excl_commit_arb.sv
module excl_commit_arb #(
  parameter int NP = 2,
  parameter int GW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] stx_vld_i,
  input  logic [GW-1:0] stx_gran_i [NP],
  input  logic [NP-1:0] st_vld_i,
  input  logic [GW-1:0] st_gran_i [NP],
  input  logic [NP-1:0] ldx_vld_i,
  input  logic [GW-1:0] ldx_gran_i [NP],
  input  logic [NP-1:0] exc_i,
  input  logic [NP-1:0] tag_i,
  input  logic [NP-1:0] gvalid_i,
  input  logic [GW-1:0] ggran_i [NP],
  output logic [NP-1:0] win_o,
  output logic [NP-1:0] we_o,
  output logic [NP-1:0] kill_held_o,
  output logic [NP-1:0] kill_new_o
);

  logic [NP-1:0] cand;
  logic [NP-1:0] blocked;
  logic [GW-1:0] wr_gran [NP];

  function automatic logic hit(input logic en, input logic [GW-1:0] a,
                               input logic [GW-1:0] b);
    return en && (a == b);
  endfunction

  // Store-exclusives that pass their own port's checks
  always_comb begin
    for (int i = 0; i < NP; i++)
      cand[i] = stx_vld_i[i] && !exc_i[i] && tag_i[i] &&
                hit(gvalid_i[i], ggran_i[i], stx_gran_i[i]);
  end

  // Same-cycle conflicts: lower-index candidate or another port's plain store
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < NP; j++) begin
        if (j < i && hit(cand[j], stx_gran_i[j], stx_gran_i[i])) blocked[i] = 1'b1;
        if (j != i && hit(st_vld_i[j], st_gran_i[j], stx_gran_i[i])) blocked[i] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      win_o[i]   = cand[i] && !blocked[i];
      we_o[i]    = st_vld_i[i] || win_o[i];
      wr_gran[i] = win_o[i] ? stx_gran_i[i] : st_gran_i[i];
    end
  end

  // Snoop of other ports' writes against held and incoming reservations
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      kill_held_o[i] = 1'b0;
      kill_new_o[i]  = 1'b0;
      for (int j = 0; j < NP; j++) begin
        if (j != i && hit(we_o[j], wr_gran[j], ggran_i[i]))    kill_held_o[i] = 1'b1;
        if (j != i && hit(we_o[j], wr_gran[j], ldx_gran_i[i]) && ldx_vld_i[i])
          kill_new_o[i] = 1'b1;
      end
    end
  end

  for (genvar a = 0; a < NP; a++) begin : g_pair_a
    for (genvar b = 0; b < NP; b++) begin : g_pair_b
      if (a < b) begin : g_lt
        AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
          (stx_vld_i[a] && stx_vld_i[b] && stx_gran_i[a] == stx_gran_i[b])
            |-> !(win_o[a] && win_o[b])); // R8
      end
      if (a != b) begin : g_ne
        AST_STORE_BLOCKS_SC: assert property (@(posedge clk) disable iff (!rst_n)
          (st_vld_i[b] && stx_vld_i[a] && st_gran_i[b] == stx_gran_i[a])
            |-> !win_o[a]); // R9
      end
    end
  end

endmodule

// File: rtl/excl_resv_monitor.sv
module excl_resv_monitor #(
  parameter int NP       = 2,
  parameter int AW       = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    ldx_vld_i,
  input  logic [NP*AW-1:0] ldx_addr_i,
  input  logic [NP-1:0]    stx_vld_i,
  input  logic [NP*AW-1:0] stx_addr_i,
  input  logic [NP-1:0]    clrx_i,
  input  logic [NP-1:0]    exc_i,
  input  logic [NP-1:0]    st_vld_i,
  input  logic [NP*AW-1:0] st_addr_i,
  output logic [NP-1:0]    stx_fail_o,
  output logic [NP-1:0]    mem_we_o
);

  localparam int GW  = AW - GRAN_LSB;
  localparam int LOW = NP * 3 * GRAN_LSB;

  logic [GW-1:0]  ldx_gran [NP];
  logic [GW-1:0]  stx_gran [NP];
  logic [GW-1:0]  st_gran  [NP];
  logic [GW-1:0]  ggran_q  [NP];
  logic [NP-1:0]  tag_q, gvalid_q, win, kill_held, kill_new;
  logic [LOW-1:0] low_bits;
  logic           unused_low;

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign ldx_gran[p] = ldx_addr_i[p*AW+GRAN_LSB +: GW];
    assign stx_gran[p] = stx_addr_i[p*AW+GRAN_LSB +: GW];
    assign st_gran[p]  = st_addr_i[p*AW+GRAN_LSB +: GW];
    assign low_bits[p*3*GRAN_LSB +: 3*GRAN_LSB] =
      {ldx_addr_i[p*AW +: GRAN_LSB], stx_addr_i[p*AW +: GRAN_LSB], st_addr_i[p*AW +: GRAN_LSB]};

    excl_local_tag u_tag (
      .clk    (clk),
      .rst_n  (rst_n),
      .ldx_i  (ldx_vld_i[p]),
      .stx_i  (stx_vld_i[p]),
      .clrx_i (clrx_i[p]),
      .exc_i  (exc_i[p]),
      .tag_o  (tag_q[p])
    );

    excl_global_entry #(.GW(GW)) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .ldx_i       (ldx_vld_i[p]),
      .ldx_gran_i  (ldx_gran[p]),
      .stx_i       (stx_vld_i[p]),
      .exc_i       (exc_i[p]),
      .kill_held_i (kill_held[p]),
      .kill_new_i  (kill_new[p]),
      .valid_o     (gvalid_q[p]),
      .gran_o      (ggran_q[p])
    );

    AST_CLR_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
      (clrx_i[p] && !ldx_vld_i[p] && !stx_vld_i[p] && !exc_i[p] && !kill_held[p])
        |=> ($stable(gvalid_q[p]) && $stable(ggran_q[p]))); // R5
    AST_COMMIT_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
      (stx_vld_i[p] && !stx_fail_o[p])
        |-> (tag_q[p] && gvalid_q[p] && ggran_q[p] == stx_gran[p])); // R6
    AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (stx_vld_i[p] && stx_fail_o[p] && !st_vld_i[p]) |-> !mem_we_o[p]); // R2
    AST_PLAIN_STORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      st_vld_i[p] |-> mem_we_o[p]); // R13
  end

  assign unused_low = ^low_bits;

  excl_commit_arb #(.NP(NP), .GW(GW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .stx_vld_i   (stx_vld_i),
    .stx_gran_i  (stx_gran),
    .st_vld_i    (st_vld_i),
    .st_gran_i   (st_gran),
    .ldx_vld_i   (ldx_vld_i),
    .ldx_gran_i  (ldx_gran),
    .exc_i       (exc_i),
    .tag_i       (tag_q),
    .gvalid_i    (gvalid_q),
    .ggran_i     (ggran_q),
    .win_o       (win),
    .we_o        (mem_we_o),
    .kill_held_o (kill_held),
    .kill_new_o  (kill_new)
  );

  assign stx_fail_o = stx_vld_i & ~win;

endmodule

// File: tb/excl_resv_monitor_tb.sv
module excl_resv_monitor_tb;

  localparam int NP = 2;
  localparam int AW = 32;
  localparam logic [31:0] WA = 32'h0000_1000;
  localparam logic [31:0] WB = 32'h0000_2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    ldx_vld, stx_vld, clrx, exc, st_vld;
  logic [NP*AW-1:0] ldx_addr, stx_addr, st_addr;
  logic [NP-1:0]    stx_fail, mem_we;
  logic [NP-1:0]    cap_fail, cap_we;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  excl_resv_monitor #(.NP(NP), .AW(AW), .GRAN_LSB(2)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ldx_vld_i(ldx_vld), .ldx_addr_i(ldx_addr),
    .stx_vld_i(stx_vld), .stx_addr_i(stx_addr),
    .clrx_i(clrx), .exc_i(exc),
    .st_vld_i(st_vld), .st_addr_i(st_addr),
    .stx_fail_o(stx_fail), .mem_we_o(mem_we)
  );

  task automatic clear_in();
    ldx_vld = '0; stx_vld = '0; clrx = '0; exc = '0; st_vld = '0;
    ldx_addr = '0; stx_addr = '0; st_addr = '0;
  endtask

  task automatic ldx(input int p, input logic [31:0] a);
    ldx_vld[p] = 1'b1; ldx_addr[p*AW +: AW] = a;
  endtask
  task automatic stx(input int p, input logic [31:0] a);
    stx_vld[p] = 1'b1; stx_addr[p*AW +: AW] = a;
  endtask
  task automatic st(input int p, input logic [31:0] a);
    st_vld[p] = 1'b1; st_addr[p*AW +: AW] = a;
  endtask

  // Sample outputs mid-cycle, then move to the next falling edge with idle inputs.
  task automatic tick();
    #2;
    cap_fail = stx_fail;
    cap_we   = mem_we;
    @(negedge clk);
    clear_in();
  endtask

  task automatic expect_out(input string req, input logic [1:0] ef, input logic [1:0] ew);
    checks++;
    if (cap_fail !== ef || cap_we !== ew) begin
      errors++;
      $display("FAIL %s: fail=%b we=%b expected fail=%b we=%b", req, cap_fail, cap_we, ef, ew);
    end
  endtask

  task automatic flush();
    exc = 2'b11; tick();
  endtask

  task automatic t_reset();
    tick();
    expect_out("R12 idle in reset", 2'b00, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    stx(0, WA); stx(1, WB); tick();
    expect_out("R12 no reservation after reset", 2'b11, 2'b00);
  endtask

  task automatic t_basic();
    flush();
    ldx(0, WA); tick();
    expect_out("R2 no status without store-exclusive", 2'b00, 2'b00);
    stx(0, WA); tick();
    expect_out("R6 matching store-exclusive commits", 2'b00, 2'b01);
    stx(0, WA); tick();
    expect_out("R3 tag cleared after success", 2'b01, 2'b00);
  endtask

  task automatic t_granule();
    flush();
    ldx(0, WA); tick();
    stx(0, WA + 32'd3); tick();
    expect_out("R6 byte offset in same word commits", 2'b00, 2'b01);
    ldx(0, WA); tick();
    stx(0, WA + 32'd4); tick();
    expect_out("R6 next word fails", 2'b01, 2'b00);
    stx(0, WA); tick();
    expect_out("R3 tag cleared after failure", 2'b01, 2'b00);
  endtask

  task automatic t_exception();
    flush();
    ldx(1, WB); tick();
    exc[1] = 1'b1; tick();
    stx(1, WB); tick();
    expect_out("R4 exception drops reservation", 2'b10, 2'b00);
    ldx(1, WB); tick();
    stx(1, WB); exc[1] = 1'b1; tick();
    expect_out("R4 store-exclusive with exception fails", 2'b10, 2'b00);
    ldx(0, WA); exc[0] = 1'b1; tick();
    stx(0, WA); tick();
    expect_out("R1 exception overrides load", 2'b01, 2'b00);
  endtask

  task automatic t_clear();
    flush();
    ldx(0, WA); ldx(1, WB); tick();
    clrx[0] = 1'b1; tick();
    stx(0, WA); stx(1, WB); tick();
    expect_out("R5 clear drops own local tag only", 2'b01, 2'b10);
  endtask

  task automatic t_snoop();
    flush();
    ldx(0, WA); tick();
    st(1, WA + 32'd2); tick();
    expect_out("R13 plain store writes", 2'b00, 2'b10);
    stx(0, WA); tick();
    expect_out("R7 other store cancels", 2'b01, 2'b00);
    ldx(0, WA); tick();
    st(1, WB); tick();
    stx(0, WA); tick();
    expect_out("R7 store elsewhere keeps reservation", 2'b00, 2'b01);
    ldx(0, WA); tick();
    st(0, WA); tick();
    stx(0, WA); tick();
    expect_out("R7 own store keeps reservation", 2'b00, 2'b01);
    ldx(0, WA); ldx(1, WA); tick();
    stx(1, WA); tick();
    expect_out("R7 port1 commits first", 2'b00, 2'b10);
    stx(0, WA); tick();
    expect_out("R7 committed store-exclusive cancels", 2'b01, 2'b00);
    flush();
    ldx(0, WA); tick();
    stx(1, WA); tick();
    expect_out("R7 failed store-exclusive by port1", 2'b10, 2'b00);
    stx(0, WA); tick();
    expect_out("R7 failed store-exclusive cancels nothing", 2'b00, 2'b01);
  endtask

  task automatic t_same_cycle();
    flush();
    ldx(0, WA); ldx(1, WA); tick();
    stx(0, WA); stx(1, WA); tick();
    expect_out("R8 lowest index wins", 2'b10, 2'b01);
    ldx(0, WA); ldx(1, WB); tick();
    stx(0, WA); stx(1, WB); tick();
    expect_out("R8 different words both commit", 2'b00, 2'b11);
    ldx(1, WB); tick();
    stx(1, WB); st(0, WB); tick();
    expect_out("R9 same-cycle plain store blocks", 2'b10, 2'b01);
    ldx(0, WA); st(1, WA); tick();
    stx(0, WA); tick();
    expect_out("R10 same-cycle write beats new load", 2'b01, 2'b00);
  endtask

  task automatic t_replace();
    flush();
    ldx(0, WA); tick();
    ldx(0, WB); tick();
    stx(0, WA); tick();
    expect_out("R11 older reservation replaced", 2'b01, 2'b00);
    ldx(0, WA); tick();
    ldx(0, WB); tick();
    stx(0, WB); tick();
    expect_out("R1 newest reservation commits", 2'b00, 2'b01);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_granule();
    t_exception();
    t_clear();
    t_snoop();
    t_same_cycle();
    t_replace();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule